// File: doc/BRIEF.md
# Codec Serial Control Port

This block is the control side of an audio codec's serial port. A host sends 16-bit control words, MSB first, on a serial data line. A frame-sync pulse marks the first bit of each word. Each word either writes one byte into a small bank of control registers or asks for that register to be read. On a read, the addressed byte comes back on a serial data output in the same frame. That output has its own drive enable, so the line can be shared and left undriven outside a frame.

Two registers have fixed roles.

- **Register 0 (main control):**
  - It holds the digital loopback enable.
  - It holds a self-clearing software reset bit.
- **Register 1 (status/control):**
  - It carries a sticky overflow flag. An event strobe from the decimator sets the flag, and a read of the register clears it.

The block has three ways to stop activity:

- A reset pin, which clears everything.
- The software reset bit, which has the same effect as the pin.
- A power-down input, which stops and clears only the framing logic and keeps the register contents.

The whole block runs on the serial bit clock.

Top module: `codec_ctrl_port`

## Requirements
- R1: When `rst` is high at a clock edge, all registers, the overflow flag, `sdout` and `sdout_en` are cleared from the next cycle.
- R2: A control word is 16 bits, MSB first. Bit 15 is sampled in the cycle where `fsync` is high, and bits 14..0 are sampled in the 15 cycles that follow. Bits 15..14 are ignored, bit 13 is the read flag, bits 12..8 are the address and bits 7..0 are the data. A word with bit 13 = 0 whose address is below `NREG` stores its data in that register. The new value is visible on `reg_bus` (byte n at bits 8n+7..8n) two cycles after the last bit.
- R3: `sdout_en` goes high in the cycle after an `fsync` cycle and stays high for 15 cycles. Outside read data, `sdout` is 0.
- R4: A word with bit 13 = 1 writes nothing. `sdout` carries bits 7..0 of the addressed register, MSB first, in the same cycles in which the host sends data bits 7..0. For register 1, bit 0 of the returned byte is the overflow flag.
- R5: A read puts a register in read mode only for its own frame. The next word with bit 13 = 0 writes normally.
- R6: A write to an address at or above `NREG` changes nothing. A read of such an address returns 0.
- R7: Writing register 0 with bit 7 set clears every register and the overflow flag, as a reset does. Bit 7 of register 0 always reads 0.
- R8: `loop_en` equals bit 2 of register 0.
- R9: An `ovf_evt` pulse sets the overflow flag (`ovf_flag`, shown at bit 0 of register 1) from the next cycle. The flag stays set across writes to register 1, because that bit cannot be written.
- R10: A completed read of register 1 clears the overflow flag two cycles after its last bit.
- R11: If `ovf_evt` is seen at any point from that read's `fsync` cycle to the cycle after its last bit, the flag stays set after the read.
- R12: While `pwrdn` is high, the frame in progress is dropped, `sdout_en` is low from the next cycle, and no word is accepted. Register contents are kept.
- R13: An `fsync` in the middle of a frame drops the partial word and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, high in the cycle of word bit 15 |
| sdin | input | 1 | Serial control data in |
| pwrdn | input | 1 | Power-down, clears framing and keeps registers |
| ovf_evt | input | 1 | Overflow event strobe |
| sdout | output | 1 | Serial read-back data |
| sdout_en | output | 1 | Drive enable for `sdout` |
| loop_en | output | 1 | Digital loopback enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| reg_bus | output | NREG*8 | All register contents, register n at bits 8n+7..8n |

## Verification
The assertions check the following on every cycle:

- The output enable rises only after a frame sync.
- The data line is quiet whenever the enable is low.
- An overflow event always leaves the flag set.
- Power-down drops the enable and freezes the register contents.
- Register 0 and the falling flag change only on a completed word.

Some behaviour only the bench's scenarios can show:

- The serial position of the read-back bits.
- That a read blocks the write in its own frame.
- That a later frame returns the register to write mode.
- The race between an overflow event and a status read.
- A restart in the middle of a frame.
- The effect of a software reset.

// File: rtl/codec_ctrl_pkg.sv
package codec_ctrl_pkg;

  localparam int WORD_W   = 16;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int ADDR_LSB = 8;
  localparam int RD_POS   = 13;

  localparam int REG_MAIN = 0;
  localparam int REG_STAT = 1;
  localparam int SRST_POS = 7;
  localparam int LOOP_POS = 2;
  localparam int OVF_POS  = 0;

  typedef struct packed {
    logic [1:0]        rsv;
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/ccp_deframer.sv
module ccp_deframer
  import codec_ctrl_pkg::*;
#(
  parameter int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fsync,
  input  logic              sdin,
  output logic              active,
  output logic [CNT_W-1:0]  cnt,
  output logic              hdr_v,
  output logic              hdr_rd,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              word_v,
  output logic [WORD_W-1:0] word
);

  localparam int SH_W = WORD_W - 1;

  logic [SH_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      word_v <= 1'b0;
      word   <= '0;
    end else begin
      word_v <= 1'b0;
      if (fsync) begin
        active <= 1'b1;
        cnt    <= CNT_W'(WORD_W - 2);
        sh     <= {{(SH_W-1){1'b0}}, sdin};
      end else if (active) begin
        sh <= {sh[SH_W-2:0], sdin};
        if (cnt == '0) begin
          active <= 1'b0;
          word_v <= 1'b1;
          word   <= {sh, sdin};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // Header peek: when the last address bit is on the wire, the rest of the
  // header already sits in the low end of the shifter.
  assign hdr_v    = active && !fsync && (cnt == CNT_W'(ADDR_LSB));
  assign hdr_rd   = sh[RD_POS-ADDR_LSB-1];
  assign hdr_addr = {sh[ADDR_W-2:0], sdin};

endmodule

// File: rtl/ccp_regfile.sv
module ccp_regfile
  import codec_ctrl_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pwrdn,
  input  logic               fsync,
  input  logic               ovf_evt,
  input  logic               word_v,
  input  logic [WORD_W-1:0]  word,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               srst,
  output logic [NREG*DATA_W-1:0] reg_bus,
  output logic               ovf_flag,
  output logic               loop_en
);

  cmd_t cmd;
  logic wr_go, rd_stat, evt_seen;
  logic [DATA_W-1:0] view [NREG];
  logic unused_rsv;

  assign cmd        = cmd_t'(word);
  assign unused_rsv = ^cmd.rsv;
  assign wr_go      = word_v && !pwrdn && !cmd.rd;
  assign rd_stat    = word_v && !pwrdn && cmd.rd && (cmd.addr == ADDR_W'(REG_STAT));
  assign srst       = wr_go && (cmd.addr == ADDR_W'(REG_MAIN)) && cmd.data[SRST_POS];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] KEEP =
      (i == REG_MAIN) ? ~(ONE << SRST_POS) :
      (i == REG_STAT) ? ~(ONE << OVF_POS)  : '1;
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk) begin
      if (rst || srst)
        q <= '0;
      else if (wr_go && (cmd.addr == ADDR_W'(i)))
        q <= cmd.data & KEEP;
    end

    if (i == REG_STAT) begin : g_stat
      assign view[i] = q | (DATA_W'(ovf_flag) << OVF_POS);
    end else begin : g_plain
      assign view[i] = q;
    end
    assign reg_bus[i*DATA_W +: DATA_W] = view[i];
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      ovf_flag <= 1'b0;
      evt_seen <= 1'b0;
    end else begin
      if (ovf_evt)
        ovf_flag <= 1'b1;
      else if (rd_stat && !evt_seen)
        ovf_flag <= 1'b0;
      if (fsync)
        evt_seen <= ovf_evt;
      else if (ovf_evt)
        evt_seen <= 1'b1;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = view[i];
  end

  assign loop_en = g_reg[REG_MAIN].q[LOOP_POS];

endmodule

// File: rtl/ccp_readout.sv
module ccp_readout
  import codec_ctrl_pkg::*;
#(
  parameter int CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              fsync,
  input  logic              active,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hdr_v,
  input  logic              hdr_rd,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sdout,
  output logic              sdout_en
);

  logic              rmode;
  logic [DATA_W-2:0] rsh;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sdout_en <= 1'b0;
      sdout    <= 1'b0;
      rmode    <= 1'b0;
      rsh      <= '0;
    end else begin
      sdout_en <= fsync || (active && (cnt != '0));
      if (fsync) begin
        sdout <= 1'b0;
        rmode <= 1'b0;
      end else if (hdr_v && hdr_rd) begin
        sdout <= rd_data[DATA_W-1];
        rsh   <= rd_data[DATA_W-2:0];
        rmode <= 1'b1;
      end else if (rmode && active && (cnt != '0)) begin
        sdout <= rsh[DATA_W-2];
        rsh   <= {rsh[DATA_W-3:0], 1'b0};
      end else begin
        sdout <= 1'b0;
        rmode <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
  import codec_ctrl_pkg::*;
#(
  parameter int NREG = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fsync,
  input  logic                   sdin,
  input  logic                   pwrdn,
  input  logic                   ovf_evt,
  output logic                   sdout,
  output logic                   sdout_en,
  output logic                   loop_en,
  output logic                   ovf_flag,
  output logic [NREG*DATA_W-1:0] reg_bus
);

  localparam int CNT_W = $clog2(WORD_W);

  logic              frm_active, frm_hdr_v, frm_hdr_rd, frm_word_v, srst, clr;
  logic [CNT_W-1:0]  frm_cnt;
  logic [ADDR_W-1:0] frm_hdr_addr;
  logic [WORD_W-1:0] frm_word;
  logic [DATA_W-1:0] rd_data;

  assign clr = pwrdn || srst;

  ccp_deframer #(.CNT_W(CNT_W)) u_frm (
    .clk(clk), .rst(rst), .clr(clr), .fsync(fsync), .sdin(sdin),
    .active(frm_active), .cnt(frm_cnt), .hdr_v(frm_hdr_v),
    .hdr_rd(frm_hdr_rd), .hdr_addr(frm_hdr_addr),
    .word_v(frm_word_v), .word(frm_word)
  );

  ccp_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst(rst), .pwrdn(pwrdn), .fsync(fsync), .ovf_evt(ovf_evt),
    .word_v(frm_word_v), .word(frm_word), .rd_addr(frm_hdr_addr),
    .rd_data(rd_data), .srst(srst), .reg_bus(reg_bus),
    .ovf_flag(ovf_flag), .loop_en(loop_en)
  );

  ccp_readout #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst(rst), .clr(clr), .fsync(fsync), .active(frm_active),
    .cnt(frm_cnt), .hdr_v(frm_hdr_v), .hdr_rd(frm_hdr_rd),
    .rd_data(rd_data), .sdout(sdout), .sdout_en(sdout_en)
  );

endmodule

// File: rtl/codec_ctrl_port_chk.sv
module codec_ctrl_port_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fsync,
  input logic             pwrdn,
  input logic             ovf_evt,
  input logic             sdout,
  input logic             sdout_en,
  input logic             ovf_flag,
  input logic             frm_word_v,
  input logic [BUS_W-1:0] reg_bus
);

  // R3
  en_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sdout_en) |-> $past(fsync));

  // R3
  quiet_line_chk: assert property (@(posedge clk) disable iff (rst)
    !sdout_en |-> !sdout);

  // R9
  ovf_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> ovf_flag);

  // R12
  pwrdn_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    pwrdn |=> !sdout_en);

  // R12
  pwrdn_keeps_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (pwrdn && !ovf_evt) |=> $stable(reg_bus));

  // R10
  flag_clear_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> $past(frm_word_v));

  // R2
  main_reg_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_bus[7:0]) |-> $past(frm_word_v));

endmodule

bind codec_ctrl_port codec_ctrl_port_chk #(.BUS_W(NREG*8)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .pwrdn(pwrdn), .ovf_evt(ovf_evt),
  .sdout(sdout), .sdout_en(sdout_en), .ovf_flag(ovf_flag),
  .frm_word_v(frm_word_v), .reg_bus(reg_bus)
);

// File: tb/codec_ctrl_port_tb.sv
module codec_ctrl_port_tb;
  localparam int NREG = 4;

  logic clk = 1'b0, rst = 1'b1, fsync = 1'b0, sdin = 1'b0;
  logic pwrdn = 1'b0, ovf_evt = 1'b0;
  logic sdout, sdout_en, loop_en, ovf_flag;
  logic [NREG*8-1:0] reg_bus;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  codec_ctrl_port #(.NREG(NREG)) u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .sdin(sdin), .pwrdn(pwrdn),
    .ovf_evt(ovf_evt), .sdout(sdout), .sdout_en(sdout_en),
    .loop_en(loop_en), .ovf_flag(ovf_flag), .reg_bus(reg_bus)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_reg [NREG];
  bit          m_flag, m_seen, m_en, m_sd, m_rmode, m_done;
  int          m_pos, m_ridx;
  logic [15:0] m_word, m_dword;
  logic [7:0]  m_rbuf;

  function automatic logic [7:0] m_view(input int a);
    if (a >= NREG) return 8'h00;
    if (a == 1) return m_reg[1] | {7'b0, m_flag};
    return m_reg[a];
  endfunction

  always @(posedge clk) begin : model
    int a; bit r, sr, dn; logic [7:0] d; logic [15:0] nw;
    if (rst) begin
      for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
      m_flag = 0; m_seen = 0; m_en = 0; m_sd = 0; m_rmode = 0; m_done = 0;
      m_pos = 0; m_ridx = 0; m_word = 0; m_dword = 0; m_rbuf = 0;
    end else begin
      a = int'(m_dword[12:8]); r = m_dword[13]; d = m_dword[7:0];
      sr = m_done && !pwrdn && !r && a == 0 && d[7];
      dn = 0; nw = m_dword;
      if (pwrdn || sr) begin
        m_pos = 0; m_en = 0; m_sd = 0; m_rmode = 0;
      end else if (fsync) begin
        m_pos = 1; m_word = {15'b0, sdin}; m_en = 1; m_sd = 0; m_rmode = 0;
      end else if (m_pos > 0) begin
        m_word = {m_word[14:0], sdin};
        m_pos++;
        if (m_pos == 16) begin
          m_en = 0; m_sd = 0; m_rmode = 0; dn = 1; nw = m_word; m_pos = 0;
        end else begin
          m_en = 1;
          if (m_pos == 8) begin
            if (m_word[5]) begin
              m_rbuf = m_view(int'(m_word[4:0]));
              m_sd = m_rbuf[7]; m_ridx = 6; m_rmode = 1;
            end else begin
              m_sd = 0; m_rmode = 0;
            end
          end else if (m_rmode && m_pos > 8) begin
            m_sd = m_rbuf[m_ridx]; m_ridx--;
          end else begin
            m_sd = 0;
          end
        end
      end else begin
        m_en = 0; m_sd = 0; m_rmode = 0;
      end
      if (sr) begin
        for (int i = 0; i < NREG; i++) m_reg[i] = 8'h00;
        m_flag = 0; m_seen = 0;
      end else begin
        if (m_done && !pwrdn && !r && a < NREG)
          m_reg[a] = (a == 0) ? (d & 8'h7F) : (a == 1) ? (d & 8'hFE) : d;
        if (ovf_evt) m_flag = 1;
        else if (m_done && !pwrdn && r && a == 1 && !m_seen) m_flag = 0;
        if (fsync) m_seen = ovf_evt;
        else if (ovf_evt) m_seen = 1;
      end
      m_done = dn; m_dword = nw;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 sdout_en vs model", 32'(sdout_en), 32'(m_en));
      chk("R4 sdout vs model", 32'(sdout), 32'(m_sd));
      chk("R2 reg_bus vs model", reg_bus, {m_reg[3], m_reg[2], m_reg[1] | {7'b0, m_flag}, m_reg[0]});
      chk("R9 ovf_flag vs model", 32'(ovf_flag), 32'(m_flag));
      chk("R8 loop_en vs model", 32'(loop_en), 32'(m_reg[0][2]));
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] cw(input bit rd, input logic [4:0] a, input logic [7:0] d);
    return {2'b00, rd, a, d};
  endfunction

  task automatic send(input logic [15:0] w, input int nbits, input int ovf_at,
                      output logic [7:0] rb);
    rb = 8'h00;
    for (int k = 0; k < nbits; k++) begin
      @(negedge clk);
      if (15 - k <= 7) rb[15-k] = sdout;
      fsync = (k == 0); sdin = w[15-k]; ovf_evt = (k == ovf_at);
    end
    @(negedge clk);
    fsync = 0; sdin = 0; ovf_evt = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ovf();
    @(negedge clk); ovf_evt = 1;
    @(negedge clk); ovf_evt = 0;
  endtask

  logic [7:0] rb;

  initial begin
    idle(3);
    rst = 0;
    idle(1);
    chk("R1 reset reg_bus", reg_bus, 32'h0);
    chk("R1 reset sdout_en", 32'(sdout_en), 32'h0);
    chk("R1 reset ovf_flag", 32'(ovf_flag), 32'h0);

    send(cw(0, 5'd2, 8'hA5), 16, -1, rb); idle(2);
    chk("R2 write reg2", 32'(reg_bus[23:16]), 32'hA5);
    send(16'hC000 | cw(0, 5'd3, 8'h3C), 16, -1, rb); idle(2);
    chk("R2 reserved bits ignored", 32'(reg_bus[31:24]), 32'h3C);

    send(cw(1, 5'd2, 8'hFF), 16, -1, rb); idle(2);
    chk("R4 read data reg2", 32'(rb), 32'hA5);
    chk("R4 read frame no write", 32'(reg_bus[23:16]), 32'hA5);

    send(cw(0, 5'd2, 8'h5A), 16, -1, rb); idle(2);
    chk("R5 write after read", 32'(reg_bus[23:16]), 32'h5A);

    send(cw(0, 5'd9, 8'h77), 16, -1, rb); idle(2);
    chk("R6 out of range write", reg_bus, 32'h3C5A0000);
    send(cw(1, 5'd9, 8'h00), 16, -1, rb); idle(2);
    chk("R6 out of range read", 32'(rb), 32'h0);

    send(cw(0, 5'd0, 8'h04), 16, -1, rb); idle(2);
    chk("R8 loop_en set", 32'(loop_en), 32'h1);

    send(cw(0, 5'd1, 8'hF0), 16, -1, rb); idle(2);
    chk("R9 reg1 write", 32'(reg_bus[15:8]), 32'hF0);
    pulse_ovf(); idle(1);
    chk("R9 flag set", 32'(ovf_flag), 32'h1);
    send(cw(0, 5'd1, 8'h00), 16, -1, rb); idle(2);
    chk("R9 flag survives write", 32'(reg_bus[15:8]), 32'h01);
    send(cw(0, 5'd1, 8'hF0), 16, -1, rb); idle(2);

    send(cw(1, 5'd1, 8'h00), 16, -1, rb); idle(2);
    chk("R10 read shows flag", 32'(rb), 32'hF1);
    chk("R10 flag cleared by read", 32'(ovf_flag), 32'h0);

    send(cw(1, 5'd1, 8'h00), 16, 10, rb); idle(2);
    chk("R11 read before event", 32'(rb), 32'hF0);
    chk("R11 event wins over read", 32'(ovf_flag), 32'h1);
    send(cw(1, 5'd1, 8'h00), 16, -1, rb); idle(2);
    chk("R10 second read clears", 32'(ovf_flag), 32'h0);

    send(cw(0, 5'd2, 8'h33), 6, -1, rb);
    @(negedge clk); pwrdn = 1;
    @(negedge clk);
    chk("R12 enable drops", 32'(sdout_en), 32'h0);
    send(cw(0, 5'd2, 8'h99), 16, -1, rb); idle(2);
    chk("R12 frame ignored", 32'(reg_bus[23:16]), 32'h5A);
    pwrdn = 0; idle(20);
    chk("R12 registers kept", reg_bus, 32'h3C5AF004);

    send(cw(0, 5'd3, 8'h11), 10, -1, rb);
    send(cw(0, 5'd3, 8'h22), 16, -1, rb); idle(2);
    chk("R13 restart frame", 32'(reg_bus[31:24]), 32'h22);

    pulse_ovf();
    send(cw(0, 5'd0, 8'h84), 16, -1, rb); idle(2);
    chk("R7 soft reset regs", reg_bus, 32'h0);
    chk("R7 soft reset flag", 32'(ovf_flag), 32'h0);
    chk("R7 soft reset loop", 32'(loop_en), 32'h0);

    send(cw(0, 5'd2, 8'h12), 16, -1, rb); idle(2);
    @(negedge clk); rst = 1;
    idle(2); rst = 0; idle(1);
    chk("R1 reset pin clears", reg_bus, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule